// File: doc/BRIEF.md
# Predicated Issue Stage with Condition Scoreboard

This block sits at the issue point of an in-order pipeline. Any instruction may name a condition register in addition to its two source registers. The block reads that register through a third register-file read port. It decides whether the instruction retires as a real operation or passes on as a harmless bubble. A zero condition squashes the instruction: its destination write and any memory access are both switched off. A non-zero condition lets it complete normally. Instructions that are not marked as predicated ignore the condition entirely.

A scoreboard holds one pending bit per architectural register. The bit is set when an enabled instruction that targets the register is issued, and it is cleared when that register's writeback is reported. While the condition register of a predicated instruction is pending, the block raises a stall. The stall holds the upstream stage and sends a bubble downstream. A squashed instruction still moves down the pipe with its valid bit set and all of its effects disabled, so program order is kept.

Top module: `pred_issue`

## Requirements
- R1: After reset the issue outputs are idle (iss_valid, iss_wb_en and iss_mem_en all 0), and no register is pending, so no predicated instruction stalls.
- R2: The third read port address rd_addr_p equals in_pred, and the source ports rd_addr_a and rd_addr_b equal in_src_a and in_src_b, in the same cycle.
- R3: A predicated instruction whose condition value is zero issues on the next clock edge with iss_valid=1, iss_wb_en=0 and iss_mem_en=0.
- R4: A predicated instruction whose condition value is non-zero issues with iss_wb_en=1, and iss_mem_en is set exactly when the opcode's most significant bit is 1 (that bit marks a memory operation).
- R5: A non-predicated instruction never stalls and always issues with iss_wb_en=1, whatever its condition register holds.
- R6: An enabled issue marks its destination pending. A predicated instruction whose condition register is pending raises stall in the same cycle, and iss_valid is 0 after the following edge.
- R7: wb_valid with wb_dst clears that register's pending bit at the clock edge, and a predicated instruction waiting on it issues from the next cycle on.
- R8: A squashed instruction does not mark its destination pending.
- R9: An issued instruction presents its opcode, its destination and both source operand values (read through rd_data_a and rd_data_b) on the issue outputs.
- R10: When an enabled issue and a writeback name the same register at the same edge, that register ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction is valid |
| in_op | input | OPW | Opcode; MSB set means memory operation |
| in_dst | input | AW | Destination register |
| in_src_a | input | AW | First source register |
| in_src_b | input | AW | Second source register |
| in_pred | input | AW | Condition register |
| in_predicated | input | 1 | Instruction is conditional |
| rd_addr_a | output | AW | Read port A address |
| rd_addr_b | output | AW | Read port B address |
| rd_addr_p | output | AW | Condition read port address |
| rd_data_a | input | DW | Read port A data |
| rd_data_b | input | DW | Read port B data |
| rd_data_p | input | DW | Condition read data |
| wb_valid | input | 1 | A writeback completed |
| wb_dst | input | AW | Register that was written back |
| stall | output | 1 | Hold upstream; no instruction issues |
| iss_valid | output | 1 | Issue slot holds an instruction (real or squashed) |
| iss_op | output | OPW | Issued opcode |
| iss_dst | output | AW | Issued destination |
| iss_a | output | DW | Issued first operand |
| iss_b | output | DW | Issued second operand |
| iss_wb_en | output | 1 | Destination write is enabled |
| iss_mem_en | output | 1 | Memory access is enabled |

## Verification
The read-port addresses and stall are combinational, so the bench checks them 1 ns after it drives inputs on the falling edge. It checks them before the rising edge that would act on them. The issue outputs and the pending bits change on the rising edge, so the bench checks issue results at the falling edge that follows, which is one cycle after the stimulus. It updates its own pending model at that same edge, using clear-then-set ordering. A writeback therefore releases a stall in the cycle after the writeback is presented, and the bench expects stall to stay high in the cycle in which wb_valid is driven.

// File: rtl/pred_issue.sv
module pred_issue #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int OPW  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] in_op,
  input  logic [AW-1:0]  in_dst,
  input  logic [AW-1:0]  in_src_a,
  input  logic [AW-1:0]  in_src_b,
  input  logic [AW-1:0]  in_pred,
  input  logic           in_predicated,
  output logic [AW-1:0]  rd_addr_a,
  output logic [AW-1:0]  rd_addr_b,
  output logic [AW-1:0]  rd_addr_p,
  input  logic [DW-1:0]  rd_data_a,
  input  logic [DW-1:0]  rd_data_b,
  input  logic [DW-1:0]  rd_data_p,
  input  logic           wb_valid,
  input  logic [AW-1:0]  wb_dst,
  output logic           stall,
  output logic           iss_valid,
  output logic [OPW-1:0] iss_op,
  output logic [AW-1:0]  iss_dst,
  output logic [DW-1:0]  iss_a,
  output logic [DW-1:0]  iss_b,
  output logic           iss_wb_en,
  output logic           iss_mem_en
);

  logic [NREG-1:0] pending, pending_nxt;
  logic go, en;

  assign rd_addr_a = in_src_a;
  assign rd_addr_b = in_src_b;
  assign rd_addr_p = in_pred;

  assign stall = in_valid & in_predicated & pending[in_pred];
  assign go    = in_valid & ~stall;
  assign en    = ~in_predicated | (rd_data_p != '0);

  // clear first, then set: a new writer wins over a retiring one
  always_comb begin
    pending_nxt = pending;
    if (wb_valid)  pending_nxt[wb_dst] = 1'b0;
    if (go && en)  pending_nxt[in_dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= '0;
      iss_valid  <= 1'b0;
      iss_wb_en  <= 1'b0;
      iss_mem_en <= 1'b0;
      iss_op     <= '0;
      iss_dst    <= '0;
      iss_a      <= '0;
      iss_b      <= '0;
    end else begin
      pending    <= pending_nxt;
      iss_valid  <= go;
      iss_wb_en  <= go & en;
      iss_mem_en <= go & en & in_op[OPW-1];
      if (go) begin
        iss_op  <= in_op;
        iss_dst <= in_dst;
        iss_a   <= rd_data_a;
        iss_b   <= rd_data_b;
      end
    end
  end

  p_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && in_predicated && rd_data_p == '0)
      |=> (iss_valid && !iss_wb_en && !iss_mem_en));

  p_nonpred_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_predicated) |-> !stall);

  p_stall_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !iss_valid);

  p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && en) |=> pending[$past(in_dst)]);

  p_mem_needs_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_mem_en |-> (iss_wb_en && iss_valid));

endmodule

// File: tb/pred_issue_test.sv
module pred_issue_test;
  localparam int NREG = 8, DW = 16, OPW = 4, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_predicated = 1'b0, wb_valid = 1'b0;
  logic [OPW-1:0] in_op = '0;
  logic [AW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0, in_pred = '0, wb_dst = '0;
  logic [AW-1:0] rd_addr_a, rd_addr_b, rd_addr_p;
  logic [DW-1:0] rd_data_a, rd_data_b, rd_data_p;
  logic stall, iss_valid, iss_wb_en, iss_mem_en;
  logic [OPW-1:0] iss_op;
  logic [AW-1:0] iss_dst;
  logic [DW-1:0] iss_a, iss_b;

  logic [DW-1:0] rf [NREG];
  logic [NREG-1:0] pend = '0;
  int total = 0, bad = 0;
  bit done = 0;

  assign rd_data_a = rf[rd_addr_a];
  assign rd_data_b = rf[rd_addr_b];
  assign rd_data_p = rf[rd_addr_p];

  always #5 clk = ~clk;

  pred_issue #(.NREG(NREG), .DW(DW), .OPW(OPW)) uut (
    .clk, .rst_n, .in_valid, .in_op, .in_dst, .in_src_a, .in_src_b, .in_pred,
    .in_predicated, .rd_addr_a, .rd_addr_b, .rd_addr_p, .rd_data_a, .rd_data_b,
    .rd_data_p, .wb_valid, .wb_dst, .stall, .iss_valid, .iss_op, .iss_dst,
    .iss_a, .iss_b, .iss_wb_en, .iss_mem_en);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic cyc(string req, bit v, logic [OPW-1:0] op, logic [AW-1:0] d,
                     logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] p,
                     bit pr, bit wv, logic [AW-1:0] wd);
    bit es, ev, en;
    in_valid = v; in_op = op; in_dst = d; in_src_a = a; in_src_b = b;
    in_pred = p; in_predicated = pr; wb_valid = wv; wb_dst = wd;
    #1;
    es = v && pr && pend[p];
    ev = v && !es;
    en = !pr || (rf[p] != 0);
    chk({req, "/stall"}, {31'd0, stall}, {31'd0, es});
    if (v) begin
      chk("R2 addr_p", {29'd0, rd_addr_p}, {29'd0, p});
      chk("R2 addr_ab", {26'd0, rd_addr_a, rd_addr_b}, {26'd0, a, b});
    end
    @(posedge clk);
    if (wv) pend[wd] = 1'b0;
    if (ev && en) pend[d] = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; wb_valid = 1'b0;
    chk({req, "/valid"}, {31'd0, iss_valid}, {31'd0, ev});
    if (ev) begin
      chk({req, "/wb_en"}, {31'd0, iss_wb_en}, {31'd0, en});
      chk({req, "/mem_en"}, {31'd0, iss_mem_en}, {31'd0, en & op[OPW-1]});
      chk("R9 fields", {25'd0, iss_op, iss_dst}, {25'd0, op, d});
      chk("R9 operands", {iss_a, iss_b}, {rf[a], rf[b]});
    end else begin
      chk({req, "/bubble"}, {30'd0, iss_wb_en, iss_mem_en}, 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = (i % 2 == 1) ? DW'(i * 37 + 5) : '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 idle", {29'd0, iss_valid, iss_wb_en, iss_mem_en}, 32'd0);
    for (int p = 0; p < NREG; p++) begin
      in_valid = 1'b1; in_predicated = 1'b1; in_pred = AW'(p); #1;
      chk("R1 no pending", {31'd0, stall}, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
    end

    // sweep: condition register, predicated flag, memory bit; writeback clears dst after
    for (int p = 0; p < NREG; p++)
      for (int pr = 0; pr < 2; pr++)
        for (int m = 0; m < 2; m++) begin
          logic [AW-1:0] d = AW'((p + 3) % NREG);
          string t = (pr == 0) ? "R5" : ((rf[p] == 0) ? "R3" : "R4");
          cyc(t, 1, OPW'({m[0], 3'(p)}), d, AW'(p + 1), AW'(p + 2), AW'(p), pr[0], 0, 0);
          cyc("R7 idle", 0, 0, 0, 0, 0, 0, 0, 1, d);
        end

    // R6/R7: writer to r3, then a predicated reader of r3 stalls until writeback
    cyc("R4", 1, 4'h1, 3, 0, 1, 0, 0, 0, 0);
    cyc("R6", 1, 4'h9, 2, 1, 0, 3, 1, 0, 0);
    cyc("R6", 1, 4'h9, 2, 1, 0, 3, 1, 0, 0);
    rf[3] = 16'h0;
    cyc("R7 wb cycle", 1, 4'h9, 2, 1, 0, 3, 1, 1, 3);
    cyc("R7 released", 1, 4'h9, 2, 1, 0, 3, 1, 0, 0);
    cyc("R7 idle", 0, 0, 0, 0, 0, 0, 0, 1, 2);

    // R5: non-predicated reader of a pending register is not held
    cyc("R4", 1, 4'h2, 6, 0, 0, 1, 1, 0, 0);
    cyc("R5", 1, 4'h3, 4, 1, 1, 6, 0, 0, 0);
    cyc("R7 idle", 0, 0, 0, 0, 0, 0, 0, 1, 6);
    cyc("R7 idle", 0, 0, 0, 0, 0, 0, 0, 1, 4);

    // R8: squashed writer to r7 leaves it free
    cyc("R3", 1, 4'h8, 7, 0, 0, 0, 1, 0, 0);
    cyc("R8", 1, 4'h1, 5, 0, 0, 7, 1, 0, 0);
    cyc("R7 idle", 0, 0, 0, 0, 0, 0, 0, 1, 5);

    // R10: same-edge writeback and new writer on r5
    cyc("R4", 1, 4'h1, 5, 0, 0, 1, 1, 0, 0);
    cyc("R10", 1, 4'h1, 5, 0, 0, 1, 1, 1, 5);
    cyc("R10", 1, 4'h1, 2, 0, 0, 5, 1, 0, 0);
    chk("R10 pending kept", {31'd0, pend[5]}, 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule